// File: doc/BRIEF.md
# Flash Controller Interrupt Status Block

This block gathers the event pulses of a flash memory controller into six sticky status bits. A per-source enable register picks which of those bits may raise a single active-high, level-sensitive interrupt line. Software takes the interrupt, reads the sticky status word to learn what happened, and that read also clears the word. A second, live status word reports the present condition of the flash and controller ready lines and the ECC engine outcome, including a two-bit corrected-error count.

Register accesses use a simple strobe bus. Reads return data on `rd_data` one clock after the read strobe. The three byte offsets are enable 0x38, sticky status 0x3C and live status 0x48. Every other offset reads as zero and ignores writes. An event is a one-cycle high pulse on its bit of `evt_pulse`.

The interrupt line is driven by a two-state machine. In `IRQ_QUIET` the line is low. The `arm` transition moves it to `IRQ_RAISED` when any enabled sticky bit is set. The `drop` transition returns it to `IRQ_QUIET` once no enabled sticky bit remains. In the same state, `hold_quiet` and `hold_raised` keep it where it is.

Top module: `flash_irq_ctrl`

## Requirements
- R1: A high pulse on `evt_pulse[i]` sets sticky status bit i at the next clock edge, and the bit stays set until a status read. The bit assignment is: 5 flash ready, 4 controller ready, 3 decode failure, 2 decode error, 1 ECC ready, 0 write-protect fault.
- R2: A read strobe at offset 0x3C returns the sticky bits in `rd_data[5:0]` one cycle later, with the upper bits zero. The same clock edge clears every sticky bit.
- R3: An event pulse in the same cycle as a status read is not lost. The read returns the old word, and the bit of the new event is still set afterwards.
- R4: A write at offset 0x38 loads `wr_data[5:0]` into the enable register, where 1 enables that source. A read at 0x38 returns the enable register.
- R5: `irq` is high exactly one cycle after some sticky bit and its enable bit are both 1. It stays high until no such pair remains, which includes an enable written after the event.
- R6: An event whose enable bit is 0 still sets its sticky bit but never raises `irq`.
- R7: A read at 0x48 returns the live word: bit 0 flash ready, bit 1 controller ready, bit 2 ECC ready, bit 3 errors detected, bits 5:4 error count minus one, bit 6 decoder failure, bit 7 zero.
- R8: `dev_ready` is high only when both the live flash-ready and controller-ready inputs are high.
- R9: After reset the enable register, the sticky bits, `irq` and `rd_data` are all zero.
- R10: Writes at 0x3C and 0x48 change nothing. A read at any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| wr_data | input | 6 | Write data (enable field) |
| rd_data | output | 8 | Read data, valid the cycle after `bus_rd` |
| evt_pulse | input | 6 | One-cycle event pulses, one per source |
| live_flash_rdy | input | 1 | Flash device ready level |
| live_ctrl_rdy | input | 1 | Controller ready level |
| live_ecc_rdy | input | 1 | ECC result ready level |
| live_err_seen | input | 1 | Correctable errors detected |
| live_err_cnt | input | 2 | Corrected error count minus one |
| live_dec_fail | input | 1 | Uncorrectable decode failure |
| irq | output | 1 | Level-high interrupt request |
| dev_ready | output | 1 | Flash and controller both ready |

## Verification
The assertions assume that reset is low at time zero and that each event is a pulse the environment drives between edges. They also assume that a read and a write never target the status word in the same cycle with a conflicting event. The bench drives every input at the falling edge, one access per cycle, with pulses lasting a single cycle. It drives the event-during-read case on purpose, with a different bit, so that the retained bit can be told apart from the word the read returns.

// File: rtl/flash_irq_pkg.sv
`timescale 1ns/1ps
package flash_irq_pkg;
    localparam int NSRC = 6;
    localparam int LIVE_W = 7;

    // Sticky / enable bit positions (decoded by software)
    localparam int SRC_WP_FAULT  = 0;
    localparam int SRC_ECC_RDY   = 1;
    localparam int SRC_DEC_ERR   = 2;
    localparam int SRC_DEC_FAIL  = 3;
    localparam int SRC_CTRL_RDY  = 4;
    localparam int SRC_FLASH_RDY = 5;

    // Live status bit positions
    localparam int LV_FLASH  = 0;
    localparam int LV_CTRL   = 1;
    localparam int LV_ECC    = 2;
    localparam int LV_ERRS   = 3;
    localparam int LV_CNT_LO = 4;
    localparam int LV_CNT_HI = 5;
    localparam int LV_FAIL   = 6;

    localparam logic [7:0] OFS_ENABLE = 8'h38;
    localparam logic [7:0] OFS_STICKY = 8'h3C;
    localparam logic [7:0] OFS_LIVE   = 8'h48;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/flash_irq_sticky.sv
`timescale 1ns/1ps
module flash_irq_sticky #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] q_o
);
    // One flop per source; a set beats a read-clear in the same cycle.
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (set_i[i]) begin
                bit_q <= 1'b1;
            end else if (clr_i) begin
                bit_q <= 1'b0;
            end
        end
        assign q_o[i] = bit_q;
    end
endmodule

// File: rtl/flash_irq_live.sv
`timescale 1ns/1ps
module flash_irq_live
    import flash_irq_pkg::*;
(
    input  logic              flash_rdy_i,
    input  logic              ctrl_rdy_i,
    input  logic              ecc_rdy_i,
    input  logic              err_seen_i,
    input  logic [1:0]        err_cnt_i,
    input  logic              dec_fail_i,
    output logic [LIVE_W-1:0] live_o,
    output logic              both_ready_o
);
    always_comb begin
        live_o                      = '0;
        live_o[LV_FLASH]            = flash_rdy_i;
        live_o[LV_CTRL]             = ctrl_rdy_i;
        live_o[LV_ECC]              = ecc_rdy_i;
        live_o[LV_ERRS]             = err_seen_i;
        live_o[LV_CNT_HI:LV_CNT_LO] = err_cnt_i;
        live_o[LV_FAIL]             = dec_fail_i;
        both_ready_o                = flash_rdy_i & ctrl_rdy_i;
    end
endmodule

// File: rtl/flash_irq_line_fsm.sv
`timescale 1ns/1ps
module flash_irq_line_fsm
    import flash_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    output logic irq_o
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  state_d = pend_i ? IRQ_RAISED : IRQ_QUIET;   // arm / hold_quiet
            IRQ_RAISED: state_d = pend_i ? IRQ_RAISED : IRQ_QUIET;   // hold_raised / drop
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/flash_irq_ctrl.sv
`timescale 1ns/1ps
module flash_irq_ctrl
    import flash_irq_pkg::*;
#(
    parameter int AW  = 8,
    parameter int RDW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [NSRC-1:0] wr_data,
    output logic [RDW-1:0]  rd_data,
    input  logic [NSRC-1:0] evt_pulse,
    input  logic            live_flash_rdy,
    input  logic            live_ctrl_rdy,
    input  logic            live_ecc_rdy,
    input  logic            live_err_seen,
    input  logic [1:0]      live_err_cnt,
    input  logic            live_dec_fail,
    output logic            irq,
    output logic            dev_ready
);
    localparam logic [AW-1:0] A_ENABLE = AW'(OFS_ENABLE);
    localparam logic [AW-1:0] A_STICKY = AW'(OFS_STICKY);
    localparam logic [AW-1:0] A_LIVE   = AW'(OFS_LIVE);

    logic [NSRC-1:0]   mask_q;
    logic [NSRC-1:0]   sticky_q;
    logic [LIVE_W-1:0] live_w;
    logic              rd_sticky;
    logic              wr_enable;
    logic              pending;

    assign rd_sticky = bus_rd && (bus_addr == A_STICKY);
    assign wr_enable = bus_wr && (bus_addr == A_ENABLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_enable) begin
            mask_q <= wr_data;
        end
    end

    flash_irq_sticky #(.N(NSRC)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_pulse),
        .clr_i (rd_sticky),
        .q_o   (sticky_q)
    );

    flash_irq_live u_live (
        .flash_rdy_i  (live_flash_rdy),
        .ctrl_rdy_i   (live_ctrl_rdy),
        .ecc_rdy_i    (live_ecc_rdy),
        .err_seen_i   (live_err_seen),
        .err_cnt_i    (live_err_cnt),
        .dec_fail_i   (live_dec_fail),
        .live_o       (live_w),
        .both_ready_o (dev_ready)
    );

    assign pending = |(sticky_q & mask_q);

    flash_irq_line_fsm u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pending),
        .irq_o  (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (bus_rd) begin
            if (bus_addr == A_ENABLE) begin
                rd_data <= RDW'(mask_q);
            end else if (bus_addr == A_STICKY) begin
                rd_data <= RDW'(sticky_q);
            end else if (bus_addr == A_LIVE) begin
                rd_data <= RDW'(live_w);
            end else begin
                rd_data <= '0;
            end
        end
    end
endmodule

// File: rtl/flash_irq_ctrl_chk.sv
`timescale 1ns/1ps
module flash_irq_ctrl_chk
    import flash_irq_pkg::*;
#(
    parameter int AW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [NSRC-1:0] wr_data,
    input logic [NSRC-1:0] evt_pulse,
    input logic [NSRC-1:0] sticky_q,
    input logic [NSRC-1:0] mask_q,
    input logic            irq,
    input logic            dev_ready,
    input logic            live_flash_rdy,
    input logic            live_ctrl_rdy
);
    localparam logic [AW-1:0] A_ENABLE = AW'(OFS_ENABLE);
    localparam logic [AW-1:0] A_STICKY = AW'(OFS_STICKY);

    logic rd_st;
    assign rd_st = bus_rd && (bus_addr == A_STICKY);

    a_r1_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_st |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

    a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_st |=> ((sticky_q & ~$past(evt_pulse)) == '0));

    a_r3_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rd_st |=> ((sticky_q & $past(evt_pulse)) == $past(evt_pulse)));

    a_r4_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ENABLE) |=> (mask_q == $past(wr_data)));

    a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((sticky_q & mask_q) != '0));

    a_r6_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !irq);

    a_r8_ready_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ready |-> (live_flash_rdy && live_ctrl_rdy));

    a_r10_sticky_not_writable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STICKY && !bus_rd && evt_pulse == '0)
        |=> (sticky_q == $past(sticky_q)));
endmodule

bind flash_irq_ctrl flash_irq_ctrl_chk #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_rd         (bus_rd),
    .wr_data        (wr_data),
    .evt_pulse      (evt_pulse),
    .sticky_q       (sticky_q),
    .mask_q         (mask_q),
    .irq            (irq),
    .dev_ready      (dev_ready),
    .live_flash_rdy (live_flash_rdy),
    .live_ctrl_rdy  (live_ctrl_rdy)
);

// File: tb/flash_irq_ctrl_tb.sv
`timescale 1ns/1ps
module flash_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [5:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [5:0] evt_pulse = '0;
    logic       live_flash_rdy = 1'b0, live_ctrl_rdy = 1'b0, live_ecc_rdy = 1'b0;
    logic       live_err_seen = 1'b0, live_dec_fail = 1'b0;
    logic [1:0] live_err_cnt = '0;
    logic       irq, dev_ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    flash_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .wr_data(wr_data), .rd_data(rd_data),
        .evt_pulse(evt_pulse), .live_flash_rdy(live_flash_rdy),
        .live_ctrl_rdy(live_ctrl_rdy), .live_ecc_rdy(live_ecc_rdy),
        .live_err_seen(live_err_seen), .live_err_cnt(live_err_cnt),
        .live_dec_fail(live_dec_fail), .irq(irq), .dev_ready(dev_ready)
    );

    // {enable, events}
    localparam logic [11:0] VEC [6] = '{
        {6'h3F, 6'h20}, {6'h00, 6'h10}, {6'h0C, 6'h08},
        {6'h0C, 6'h03}, {6'h21, 6'h21}, {6'h12, 6'h2D}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [5:0] d);
        @(negedge clk); bus_addr = a; wr_data = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = rd_data;
    endtask

    task automatic pulse(input logic [5:0] e);
        @(negedge clk); evt_pulse = e;
        @(negedge clk); evt_pulse = '0;
    endtask

    task automatic report;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 irq", irq, 0);
        chk("R9 rd_data", rd_data, 0);
        rd_reg(8'h38, d); chk("R9 enable", d, 0);
        rd_reg(8'h3C, d); chk("R9 sticky", d, 0);

        // table walk: R1 R2 R5 R6
        foreach (VEC[i]) begin
            logic [5:0] m, e;
            m = VEC[i][11:6]; e = VEC[i][5:0];
            wr_reg(8'h38, m);
            pulse(e);
            @(negedge clk);
            chk("R5/R6 irq after event", irq, |(m & e));
            rd_reg(8'h3C, d);
            chk("R1/R2 sticky read", d, {2'b00, e});
            @(negedge clk);
            chk("R2/R5 irq after clear", irq, 0);
            rd_reg(8'h3C, d);
            chk("R2 sticky cleared", d, 0);
        end

        // R4 readback
        wr_reg(8'h38, 6'h2A);
        rd_reg(8'h38, d); chk("R4 enable readback", d, 8'h2A);

        // R3 event in the read cycle
        wr_reg(8'h38, 6'h00);
        pulse(6'h01);
        @(negedge clk); bus_addr = 8'h3C; bus_rd = 1'b1; evt_pulse = 6'h04;
        @(negedge clk); bus_rd = 1'b0; evt_pulse = '0;
        chk("R3 read returns old word", rd_data, 8'h01);
        rd_reg(8'h3C, d); chk("R3 new event retained", d, 8'h04);

        // R5 enable written after event, level held
        pulse(6'h08);
        @(negedge clk); chk("R6 masked no irq", irq, 0);
        wr_reg(8'h38, 6'h08);
        chk("R5 irq one cycle after enable", irq, 0);
        @(negedge clk); chk("R5 irq raised", irq, 1);
        repeat (3) @(negedge clk);
        chk("R5 irq level held", irq, 1);
        rd_reg(8'h3C, d);
        @(negedge clk); chk("R5 irq drops after read", irq, 0);

        // R10 writes to status words ignored, unmapped read
        wr_reg(8'h38, 6'h00);
        pulse(6'h12);
        wr_reg(8'h3C, 6'h00);
        rd_reg(8'h3C, d); chk("R10 sticky not writable", d, 8'h12);
        live_flash_rdy = 1'b1; live_ecc_rdy = 1'b1;
        wr_reg(8'h48, 6'h3F);
        rd_reg(8'h48, d); chk("R10 live not writable", d, 8'h05);
        rd_reg(8'h40, d); chk("R10 unmapped reads zero", d, 0);

        // R7 live layout
        live_flash_rdy = 1'b1; live_ctrl_rdy = 1'b0; live_ecc_rdy = 1'b1;
        live_err_seen = 1'b1; live_err_cnt = 2'd2; live_dec_fail = 1'b0;
        rd_reg(8'h48, d); chk("R7 live pattern a", d, 8'h2D);
        live_flash_rdy = 1'b0; live_ctrl_rdy = 1'b1; live_ecc_rdy = 1'b0;
        live_err_seen = 1'b1; live_err_cnt = 2'd3; live_dec_fail = 1'b1;
        rd_reg(8'h48, d); chk("R7 live pattern b", d, 8'h7A);

        // R8 ready combination
        #1 chk("R8 ctrl only", dev_ready, 0);
        live_flash_rdy = 1'b1; live_ctrl_rdy = 1'b0;
        #1 chk("R8 flash only", dev_ready, 0);
        live_ctrl_rdy = 1'b1;
        #1 chk("R8 both", dev_ready, 1);

        done = 1'b1;
        report();
    end
endmodule